// File: doc/BRIEF.md
# Flash Command Decoder

This block turns host memory cycles into a small command set for emulating a firmware flash device. It sits behind a bus front end that has already parsed each cycle. For each cycle that front end gives one strobe, together with the direction, the address, the transfer size and the write data. Reads to two command addresses return identification bytes or status bytes. A third output tells the front end not to send a SYNC, which leaves the cycle unanswered. Writes to the other command addresses change enable and error bits, start an erase, or arm writes into on-chip RAM. RAM writes go out through a simple strobe port.

Writes that change memory work on an arm-then-execute rule. An accepted block erase uses up its enable bit. A RAM write leaves its enable bit set until the host clears it with a separate command. After a RAM write, a busy flag stays set for a fixed number of cycles. While that flag is set, or while an erase is pending, the block refuses further erases and RAM writes. An erase stays pending until local firmware clears the erase-done flag with a strobe. The host polls status register 1 until it reads that flag as 0.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, rd_valid, ram_we, busy and erase_irq are 0 and erase_blk is 0. Both status registers read as 0x00.
- R2: A read of CMD_BASE+0 returns MFR_ID in rd_data[7:0] for a byte size (cyc_size 0). For a word size (cyc_size 1) it returns MFR_ID in rd_data[7:0] and DEV_ID in rd_data[15:8]. In both cases rd_nosync is 0. The byte returned first sits in the low byte.
- R3: A read of CMD_BASE+1 returns status 1 first (rd_data[7:0]) and status 2 second (rd_data[15:8]). Status 1 holds these bits: bit0 erase-done, bit1 erase error, bit2 write error, bit3 busy, bit4 erase enable, bit5 write enable, bits 7:6 zero. Status 2 holds the erase block register.
- R4: A longword read (cyc_size 2) of either read address returns rd_nosync=1 with rd_data=0. So does a read of any other address.
- R5: A write to CMD_BASE+2 clears both error bits and the erase enable bit. It leaves write enable unchanged.
- R6: A write to CMD_BASE+3 sets erase enable. A later write to CMD_BASE+4 with erase enable set does three things: it loads cyc_wdata[BLK_W-1:0] into erase_blk, it sets erase_irq, and it clears erase enable.
- R7: A write to CMD_BASE+4 with erase enable clear sets the erase error bit and changes nothing else.
- R8: A write to CMD_BASE+5 sets write enable. A write into the RAM window (address bits above RAM_AW equal to those of RAM_BASE) with write enable set pulses ram_we. ram_be is 0001 for byte, 0011 for word and 1111 for longword, and write enable stays set afterwards.
- R9: A RAM window write with write enable clear produces no ram_we and sets the write error bit.
- R10: A write to CMD_BASE+6 clears write enable.
- R11: An accepted RAM write holds busy high for BUSY_CYCLES cycles, starting in the cycle of the ram_we pulse. A RAM write or block erase that arrives while busy is high is rejected and leaves all state unchanged.
- R12: While erase_irq is set, RAM writes and block erases are rejected and leave all state unchanged. A fw_done_clr pulse while erase_irq is 1 clears it.
- R13: Every output responds in the cycle after the edge that samples cyc_valid. rd_valid is high for one cycle per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | One-cycle strobe for a parsed memory cycle |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| cyc_addr | input | ADDR_W | Cycle address |
| cyc_size | input | 2 | 0 byte, 1 word, 2 longword |
| cyc_wdata | input | 32 | Write data, first byte in bits 7:0 |
| fw_done_clr | input | 1 | Firmware strobe that clears the erase-done flag |
| rd_valid | output | 1 | Read response present |
| rd_data | output | 16 | Read bytes, first in bits 7:0 |
| rd_nosync | output | 1 | Do not answer this read |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | RAM_AW | RAM byte address |
| ram_wdata | output | 32 | RAM write data |
| ram_be | output | 4 | RAM byte enables |
| erase_blk | output | BLK_W | Erase block register |
| erase_irq | output | 1 | Erase-done interrupt flag |
| busy | output | 1 | RAM write in progress |

## Verification
The assertions assume that cyc_valid is a strobe of one cycle, with its fields valid in that same cycle. They also assume that fw_done_clr is raised only after firmware has seen the flag set. The bench drives every input at the falling edge. It raises cyc_valid for exactly one clock per transaction and pulses fw_done_clr only while erase_irq is 1. The table part leaves three idle cycles after each transaction, so busy has always cleared before the next command. The directed part then issues transactions back to back, so that commands land inside the busy window and while an erase is pending.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int               ADDR_W      = 32,
  parameter int               RAM_AW      = 12,
  parameter int               BLK_W       = 8,
  parameter int               BUSY_CYCLES = 2,
  parameter logic [ADDR_W-1:0] CMD_BASE   = 32'hFFC0_0000,
  parameter logic [ADDR_W-1:0] RAM_BASE   = 32'h0001_0000,
  parameter logic [7:0]       MFR_ID      = 8'h1C,
  parameter logic [7:0]       DEV_ID      = 8'h71
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  logic              cyc_write,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [1:0]        cyc_size,
  input  logic [31:0]       cyc_wdata,
  input  logic              fw_done_clr,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic              rd_nosync,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [31:0]       ram_wdata,
  output logic [3:0]        ram_be,
  output logic [BLK_W-1:0]  erase_blk,
  output logic              erase_irq,
  output logic              busy
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [ADDR_W-RAM_AW-1:0] RAM_PAGE = RAM_BASE[ADDR_W-1:RAM_AW];

  logic             erase_en, write_en, erase_err, write_err;
  logic [CNT_W-1:0] busy_cnt;
  logic [7:0]       st1, st2, first_b, second_b;

  wire rd_cyc = cyc_valid & ~cyc_write;
  wire wr_cyc = cyc_valid & cyc_write;

  wire hit_id   = cyc_addr == CMD_BASE;
  wire hit_st   = cyc_addr == CMD_BASE + ADDR_W'(1);
  wire hit_clr  = cyc_addr == CMD_BASE + ADDR_W'(2);
  wire hit_een  = cyc_addr == CMD_BASE + ADDR_W'(3);
  wire hit_ers  = cyc_addr == CMD_BASE + ADDR_W'(4);
  wire hit_wen  = cyc_addr == CMD_BASE + ADDR_W'(5);
  wire hit_wdis = cyc_addr == CMD_BASE + ADDR_W'(6);
  wire hit_ram  = cyc_addr[ADDR_W-1:RAM_AW] == RAM_PAGE;

  wire rd_size_ok = (cyc_size == 2'd0) | (cyc_size == 2'd1);
  wire wr_size_ok = cyc_size != 2'd3;
  wire locked     = busy | erase_irq;
  wire answer     = rd_cyc & (hit_id | hit_st) & rd_size_ok;
  wire ram_try    = wr_cyc & hit_ram & wr_size_ok & ~locked;
  wire ers_try    = wr_cyc & hit_ers & ~locked;

  assign busy = busy_cnt != '0;
  assign st1  = {2'b00, write_en, erase_en, busy, write_err, erase_err, erase_irq};
  assign st2  = 8'(erase_blk);

  assign first_b  = hit_id ? MFR_ID : st1;
  assign second_b = hit_id ? DEV_ID : st2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_nosync <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid  <= rd_cyc;
      rd_nosync <= rd_cyc & ~answer;
      if (answer)
        rd_data <= (cyc_size == 2'd1) ? {second_b, first_b} : {8'h00, first_b};
      else
        rd_data <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      ram_be    <= '0;
      busy_cnt  <= '0;
    end else begin
      ram_we <= 1'b0;
      if (ram_try & write_en) begin
        ram_we    <= 1'b1;
        ram_addr  <= cyc_addr[RAM_AW-1:0];
        ram_wdata <= cyc_wdata;
        case (cyc_size)
          2'd0:    ram_be <= 4'b0001;
          2'd1:    ram_be <= 4'b0011;
          default: ram_be <= 4'b1111;
        endcase
        busy_cnt <= CNT_W'(BUSY_CYCLES);
      end else if (busy) begin
        busy_cnt <= busy_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      erase_en  <= 1'b0;
      write_en  <= 1'b0;
      erase_err <= 1'b0;
      write_err <= 1'b0;
      erase_irq <= 1'b0;
      erase_blk <= '0;
    end else begin
      if (fw_done_clr & erase_irq) erase_irq <= 1'b0;
      if (wr_cyc & hit_clr) begin
        erase_err <= 1'b0;
        write_err <= 1'b0;
        erase_en  <= 1'b0;
      end
      if (wr_cyc & hit_een)  erase_en <= 1'b1;
      if (wr_cyc & hit_wen)  write_en <= 1'b1;
      if (wr_cyc & hit_wdis) write_en <= 1'b0;
      if (ers_try) begin
        if (erase_en) begin
          erase_blk <= cyc_wdata[BLK_W-1:0];
          erase_irq <= 1'b1;
          erase_en  <= 1'b0;
        end else begin
          erase_err <= 1'b1;
        end
      end
      if (ram_try & ~write_en) write_err <= 1'b1;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cyc_valid,
  input logic        cyc_write,
  input logic        fw_done_clr,
  input logic        rd_valid,
  input logic        rd_nosync,
  input logic [15:0] rd_data,
  input logic        ram_we,
  input logic        busy,
  input logic        erase_irq,
  input logic        erase_en,
  input logic        write_en
);

  // R8
  ram_we_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> write_en);

  // R11
  ram_we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy);

  // R11
  ram_we_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !$past(busy) && !$past(erase_irq));

  // R6
  erase_consumes_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_irq) |-> !erase_en && $past(erase_en));

  // R12
  irq_clear_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_irq) |-> $past(fw_done_clr));

  // R4
  nosync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_nosync |-> rd_data == 16'h0000);

  // R13
  rd_follows_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cyc_valid) && !$past(cyc_write));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
  .fw_done_clr(fw_done_clr), .rd_valid(rd_valid), .rd_nosync(rd_nosync),
  .rd_data(rd_data), .ram_we(ram_we), .busy(busy), .erase_irq(erase_irq),
  .erase_en(erase_en), .write_en(write_en)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
  localparam logic [31:0] CB = 32'hFFC0_0000;
  localparam logic [31:0] RB = 32'h0001_0000;
  localparam logic [31:0] A_ID = CB, A_ST = CB + 1, A_CLR = CB + 2, A_EEN = CB + 3,
                          A_ERS = CB + 4, A_WEN = CB + 5, A_WDIS = CB + 6;

  typedef struct packed {
    logic [3:0]  rq;
    logic        wr;
    logic [31:0] addr;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic        rv;
    logic        ns;
    logic [15:0] rdat;
    logic        we;
    logic [3:0]  be;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  1'b0, A_ID,        2'd0, 32'h0,          1'b1, 1'b0, 16'h001C, 1'b0, 4'h0}, // R2
    '{4'd2,  1'b0, A_ID,        2'd1, 32'h0,          1'b1, 1'b0, 16'h711C, 1'b0, 4'h0}, // R2
    '{4'd4,  1'b0, A_ID,        2'd2, 32'h0,          1'b1, 1'b1, 16'h0000, 1'b0, 4'h0}, // R4
    '{4'd3,  1'b0, A_ST,        2'd1, 32'h0,          1'b1, 1'b0, 16'h0000, 1'b0, 4'h0}, // R3
    '{4'd4,  1'b0, A_ST,        2'd2, 32'h0,          1'b1, 1'b1, 16'h0000, 1'b0, 4'h0}, // R4
    '{4'd4,  1'b0, CB + 16,     2'd1, 32'h0,          1'b1, 1'b1, 16'h0000, 1'b0, 4'h0}, // R4
    '{4'd7,  1'b1, A_ERS,       2'd0, 32'h5,          1'b0, 1'b0, 16'h0000, 1'b0, 4'h0}, // R7
    '{4'd7,  1'b0, A_ST,        2'd1, 32'h0,          1'b1, 1'b0, 16'h0002, 1'b0, 4'h0}, // R7
    '{4'd9,  1'b1, RB + 32'h10, 2'd0, 32'hAB,         1'b0, 1'b0, 16'h0000, 1'b0, 4'h0}, // R9
    '{4'd9,  1'b0, A_ST,        2'd1, 32'h0,          1'b1, 1'b0, 16'h0006, 1'b0, 4'h0}, // R9
    '{4'd5,  1'b1, A_CLR,       2'd0, 32'h0,          1'b0, 1'b0, 16'h0000, 1'b0, 4'h0}, // R5
    '{4'd5,  1'b0, A_ST,        2'd1, 32'h0,          1'b1, 1'b0, 16'h0000, 1'b0, 4'h0}, // R5
    '{4'd8,  1'b1, A_WEN,       2'd0, 32'h0,          1'b0, 1'b0, 16'h0000, 1'b0, 4'h0}, // R8
    '{4'd8,  1'b0, A_ST,        2'd0, 32'h0,          1'b1, 1'b0, 16'h0020, 1'b0, 4'h0}, // R8
    '{4'd8,  1'b1, RB + 32'h24, 2'd0, 32'h11223344,   1'b0, 1'b0, 16'h0000, 1'b1, 4'h1}, // R8
    '{4'd8,  1'b1, RB + 32'h28, 2'd1, 32'h55667788,   1'b0, 1'b0, 16'h0000, 1'b1, 4'h3}, // R8
    '{4'd8,  1'b1, RB + 32'h2C, 2'd2, 32'h99AABBCC,   1'b0, 1'b0, 16'h0000, 1'b1, 4'hF}, // R8
    '{4'd8,  1'b0, A_ST,        2'd1, 32'h0,          1'b1, 1'b0, 16'h0020, 1'b0, 4'h0}, // R8
    '{4'd5,  1'b1, A_EEN,       2'd0, 32'h0,          1'b0, 1'b0, 16'h0000, 1'b0, 4'h0}, // R5
    '{4'd5,  1'b0, A_ST,        2'd1, 32'h0,          1'b1, 1'b0, 16'h0030, 1'b0, 4'h0}, // R5
    '{4'd5,  1'b1, A_CLR,       2'd0, 32'h0,          1'b0, 1'b0, 16'h0000, 1'b0, 4'h0}, // R5
    '{4'd5,  1'b0, A_ST,        2'd1, 32'h0,          1'b1, 1'b0, 16'h0020, 1'b0, 4'h0}, // R5
    '{4'd10, 1'b1, A_WDIS,      2'd0, 32'h0,          1'b0, 1'b0, 16'h0000, 1'b0, 4'h0}, // R10
    '{4'd10, 1'b0, A_ST,        2'd1, 32'h0,          1'b1, 1'b0, 16'h0000, 1'b0, 4'h0}, // R10
    '{4'd10, 1'b1, RB + 32'h30, 2'd2, 32'h12345678,   1'b0, 1'b0, 16'h0000, 1'b0, 4'h0}, // R10
    '{4'd10, 1'b0, A_ST,        2'd1, 32'h0,          1'b1, 1'b0, 16'h0004, 1'b0, 4'h0}, // R10
    '{4'd6,  1'b1, A_EEN,       2'd0, 32'h0,          1'b0, 1'b0, 16'h0000, 1'b0, 4'h0}, // R6
    '{4'd6,  1'b1, A_ERS,       2'd0, 32'h9A,         1'b0, 1'b0, 16'h0000, 1'b0, 4'h0}, // R6
    '{4'd6,  1'b0, A_ST,        2'd1, 32'h0,          1'b1, 1'b0, 16'h9A05, 1'b0, 4'h0}  // R6
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cyc_valid = 1'b0, cyc_write = 1'b0, fw_done_clr = 1'b0;
  logic [31:0] cyc_addr = '0, cyc_wdata = '0;
  logic [1:0]  cyc_size = '0;
  logic        rd_valid, rd_nosync, ram_we, erase_irq, busy;
  logic [15:0] rd_data;
  logic [11:0] ram_addr;
  logic [31:0] ram_wdata;
  logic [3:0]  ram_be;
  logic [7:0]  erase_blk;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
    .cyc_addr(cyc_addr), .cyc_size(cyc_size), .cyc_wdata(cyc_wdata),
    .fw_done_clr(fw_done_clr), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_nosync(rd_nosync), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_be(ram_be), .erase_blk(erase_blk),
    .erase_irq(erase_irq), .busy(busy));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic xact(input logic wr, input logic [31:0] a, input logic [1:0] sz,
                      input logic [31:0] wd);
    cyc_valid = 1'b1; cyc_write = wr; cyc_addr = a; cyc_size = sz; cyc_wdata = wd;
    @(negedge clk);
    cyc_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_st(input string req, input logic [15:0] exp);
    xact(1'b0, A_ST, 2'd1, 32'h0);
    chk(req, {15'h0, rd_valid}, 32'h1);
    chk(req, {16'h0, rd_data}, {16'h0, exp});
    idle(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", {27'h0, rd_valid, ram_we, busy, erase_irq, rd_nosync}, 32'h0);
    chk("R1", {24'h0, erase_blk}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      xact(VEC[i].wr, VEC[i].addr, VEC[i].sz, VEC[i].wd);
      // R13: all outputs sampled one edge after the strobe
      chk($sformatf("R%0d rd_valid v%0d", VEC[i].rq, i), {31'h0, rd_valid}, {31'h0, VEC[i].rv});
      if (VEC[i].rv) begin
        chk($sformatf("R%0d nosync v%0d", VEC[i].rq, i), {31'h0, rd_nosync}, {31'h0, VEC[i].ns});
        chk($sformatf("R%0d rdata v%0d", VEC[i].rq, i), {16'h0, rd_data}, {16'h0, VEC[i].rdat});
      end
      chk($sformatf("R%0d ram_we v%0d", VEC[i].rq, i), {31'h0, ram_we}, {31'h0, VEC[i].we});
      if (VEC[i].we) begin
        chk($sformatf("R%0d be v%0d", VEC[i].rq, i), {28'h0, ram_be}, {28'h0, VEC[i].be});
        chk($sformatf("R%0d addr v%0d", VEC[i].rq, i), {20'h0, ram_addr}, {20'h0, VEC[i].addr[11:0]});
        chk($sformatf("R%0d wdata v%0d", VEC[i].rq, i), ram_wdata, VEC[i].wd);
      end
      idle(3);
    end
    chk("R6 erase_blk", {24'h0, erase_blk}, 32'h9A);
    chk("R6 erase_irq", {31'h0, erase_irq}, 32'h1);

    // R12: erase pending blocks RAM writes and further erases
    xact(1'b1, A_WEN, 2'd0, 32'h0);
    xact(1'b1, RB + 32'h40, 2'd2, 32'hDEAD);
    chk("R12 ram_we blocked", {31'h0, ram_we}, 32'h0);
    idle(3);
    rd_st("R12 status", 16'h9A25);
    xact(1'b1, A_EEN, 2'd0, 32'h0);
    xact(1'b1, A_ERS, 2'd0, 32'h33);
    idle(3);
    rd_st("R12 erase blocked", 16'h9A35);

    // R12: firmware clear strobe
    fw_done_clr = 1'b1;
    @(negedge clk);
    fw_done_clr = 1'b0;
    chk("R12 irq cleared", {31'h0, erase_irq}, 32'h0);
    rd_st("R12 status after clear", 16'h9A34);

    // R11: busy window, back-to-back commands
    xact(1'b1, RB + 32'h50, 2'd0, 32'h5A);
    chk("R11 ram_we", {31'h0, ram_we}, 32'h1);
    chk("R11 busy set", {31'h0, busy}, 32'h1);
    xact(1'b0, A_ST, 2'd1, 32'h0);
    chk("R11 busy in status", {16'h0, rd_data}, 32'h9A3C);
    xact(1'b1, A_ERS, 2'd0, 32'h44);
    chk("R11 busy ends", {31'h0, busy}, 32'h0);
    idle(2);
    rd_st("R11 erase rejected", 16'h9A34);
    xact(1'b1, RB + 32'h60, 2'd2, 32'h0);
    chk("R11 first write", {31'h0, ram_we}, 32'h1);
    xact(1'b1, RB + 32'h64, 2'd2, 32'h0);
    chk("R11 second write rejected", {31'h0, ram_we}, 32'h0);
    idle(3);
    rd_st("R11 no error", 16'h9A34);

    // R6: erase accepted once unlocked
    xact(1'b1, A_ERS, 2'd0, 32'h44);
    chk("R6 irq", {31'h0, erase_irq}, 32'h1);
    idle(3);
    rd_st("R6 second erase", 16'h4425);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule